// File: doc/BRIEF.md
# External Interrupt Ordered Dispatcher

This block decides which of 32 external interrupt sources the core services next. Each source line sets a sticky pending bit. A per-source enable mask and a global enable gate those bits. When any enabled bit is pending and global enable is high, the block raises a single interrupt towards the core on the shared external vector number 4. It then works out which source to report.

Priority does not come from bit position. A programmable order table lists source indices, and each table slot carries a valid flag. A length value sets how many slots are examined. The block captures the enabled pending bits into a snapshot when the scan starts. It then examines one slot per clock and stops at the first valid slot whose source is present in the snapshot. It reports that source as dispatch number 32 + k. If no slot matches, it reports a spurious result instead.

An acknowledge from the core retires the result, clears the serviced pending bit or bits, and lets the next scan begin. The table and the length are written through a plain write port. Writes are accepted only while the block is idle.

Top module: `ext_irq_dispatch`

## Requirements
- R1: After reset, irq_out, done and spurious are low, disp_num and core_vec are 0, no request is pending and the scan length is 0, so the first scan ends spurious after one scan cycle.
- R2: irq_in bit k high at a clock edge sets pending bit k. The bit stays set until the acknowledge of a result that retires it, and a pending bit that has not been retired is scanned again after the acknowledge.
- R3: While gie is low, no scan starts and irq_out stays low. Requests are still latched, and they are served once gie goes high.
- R4: A pending request whose src_en bit is 0 is not considered. If only masked requests are pending, irq_out stays low.
- R5: irq_out goes high one cycle after the idle block sees an enabled pending request with gie high. It stays high through the scan and until the acknowledge. core_vec is 4 while irq_out is high and 0 otherwise.
- R6: A matched source k is reported as disp_num = 32 + k (6 bits) with spurious low.
- R7: Table slots are examined in slot order 0, 1, 2, ..., whatever the source bit positions. When slot p is the first match, done pulses for exactly one cycle, p+1 cycles after irq_out rises.
- R8: A slot with its valid flag 0, or at a position at or beyond the length, never matches. With no match, done pulses len+1 cycles after irq_out rises, with spurious = 1 and disp_num = 0. Acknowledging a spurious result clears every snapshot bit.
- R9: The request bits that take part in a scan are those pending and enabled at the cycle the scan starts. A request that arrives later waits for the next scan.
- R10: ack while a result is held drops irq_out in the next cycle and clears the reported source's pending bit. ack while idle has no effect.
- R11: A table write (tbl_we) or a length write (len_we) is dropped while irq_out is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Request set lines, one per source |
| src_en | input | 32 | Per-source enable mask |
| gie | input | 1 | Global interrupt enable |
| ack | input | 1 | Retire the held result |
| tbl_we | input | 1 | Write one order-table slot |
| tbl_addr | input | 5 | Slot index to write |
| tbl_src | input | 5 | Source index stored in the slot |
| tbl_vld | input | 1 | Valid flag stored in the slot |
| len_we | input | 1 | Write the scan length |
| len_val | input | 6 | Scan length, 0 to 32 (larger values clamp to 32) |
| irq_out | output | 1 | Interrupt towards the core |
| core_vec | output | 5 | Shared core vector number (4 while irq_out is high) |
| done | output | 1 | One-cycle pulse when the result is ready |
| disp_num | output | 6 | Dispatch number 32 + k, or 0 when spurious |
| spurious | output | 1 | No configured slot matched |

## Verification
A request bit set at edge A starts a scan at edge A+1, so irq_out is sampled at the falling edge after that. The done pulse is due p+1 cycles later for a match in slot p, or len+1 cycles later for a spurious result. The bench counts falling edges from the first one at which irq_out is seen high and compares that count with the slot position its own table model predicts. Effects of an acknowledge and effects of dropped writes are checked one cycle after the acknowledge edge, and again through the result of the following scan.

// File: rtl/eid_pkg.sv
package eid_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WAIT = 2'd2
  } scan_st_t;
endpackage

// File: rtl/eid_req_bank.sv
module eid_req_bank #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] req_o
);
  // a new request wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) req_o <= '0;
    else     req_o <= (req_o & ~clr_i) | set_i;
  end

  // R2: a pending bit only appears after its set line was high
  p_set_only_r2: assert property (@(posedge clk) disable iff (rst)
    ((req_o & ~$past(req_o) & ~$past(set_i)) == '0));

  // R10: a cleared bit is gone one cycle later unless re-set
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~set_i) != '0) |=> ((req_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/eid_order_tbl.sv
module eid_order_tbl #(
  parameter int DEPTH = 32,
  parameter int SRC_W = 5,
  parameter int AW    = 5,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [SRC_W-1:0] wr_src_i,
  input  logic             wr_vld_i,
  input  logic             len_we_i,
  input  logic [PTR_W-1:0] len_val_i,
  input  logic [AW-1:0]    rd_ptr_i,
  output logic [SRC_W-1:0] rd_src_o,
  output logic             rd_vld_o,
  output logic [PTR_W-1:0] len_o
);
  localparam int EW = SRC_W + 1;

  // slot storage without reset so it maps onto distributed RAM
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i && !lock_i) mem[wr_addr_i] <= {wr_vld_i, wr_src_i};
  end

  assign {rd_vld_o, rd_src_o} = mem[rd_ptr_i];

  always_ff @(posedge clk) begin
    if (rst) len_o <= '0;
    else if (len_we_i && !lock_i)
      len_o <= (len_val_i > PTR_W'(DEPTH)) ? PTR_W'(DEPTH) : len_val_i;
  end

  // R11: length cannot move while a scan or result is outstanding
  p_len_locked_r11: assert property (@(posedge clk) disable iff (rst)
    lock_i |=> $stable(len_o));

  // R8: length never exceeds the table depth
  p_len_bound_r8: assert property (@(posedge clk) disable iff (rst)
    len_o <= PTR_W'(DEPTH));
endmodule

// File: rtl/eid_scan_fsm.sv
module eid_scan_fsm
  import eid_pkg::*;
#(
  parameter int NSRC      = 32,
  parameter int SRC_W     = 5,
  parameter int AW        = 5,
  parameter int PTR_W     = 6,
  parameter int DISP_W    = 6,
  parameter int DISP_BASE = 32,
  parameter int VEC_W     = 5,
  parameter int CORE_VEC  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   req_i,
  input  logic [NSRC-1:0]   en_i,
  input  logic              gie_i,
  input  logic              ack_i,
  input  logic [SRC_W-1:0]  rd_src_i,
  input  logic              rd_vld_i,
  input  logic [PTR_W-1:0]  len_i,
  output logic [AW-1:0]     rd_ptr_o,
  output logic              lock_o,
  output logic [NSRC-1:0]   clr_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  core_vec_o,
  output logic              done_o,
  output logic [DISP_W-1:0] disp_o,
  output logic              spur_o
);
  scan_st_t         st_q;
  logic [PTR_W-1:0] ptr_q;
  logic [NSRC-1:0]  snap_q;
  logic [SRC_W-1:0] hit_q;
  logic [NSRC-1:0]  pend;
  logic             at_end;
  logic             hit;

  assign pend     = req_i & en_i;
  assign at_end   = ptr_q >= len_i;
  assign hit      = rd_vld_i && snap_q[rd_src_i];
  assign rd_ptr_o = ptr_q[AW-1:0];
  assign lock_o   = (st_q != ST_IDLE);

  always_comb begin
    clr_o = '0;
    if (st_q == ST_WAIT && ack_i)
      clr_o = spur_o ? snap_q : (NSRC'(1) << hit_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      ptr_q      <= '0;
      snap_q     <= '0;
      hit_q      <= '0;
      irq_o      <= 1'b0;
      core_vec_o <= '0;
      done_o     <= 1'b0;
      disp_o     <= '0;
      spur_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (gie_i && (|pend)) begin
            st_q       <= ST_SCAN;
            snap_q     <= pend;
            ptr_q      <= '0;
            irq_o      <= 1'b1;
            core_vec_o <= VEC_W'(CORE_VEC);
            disp_o     <= '0;
            spur_o     <= 1'b0;
          end
        end
        ST_SCAN: begin
          if (at_end) begin
            st_q   <= ST_WAIT;
            done_o <= 1'b1;
            spur_o <= 1'b1;
            disp_o <= '0;
          end else if (hit) begin
            st_q   <= ST_WAIT;
            done_o <= 1'b1;
            spur_o <= 1'b0;
            disp_o <= DISP_W'(DISP_BASE) + DISP_W'(rd_src_i);
            hit_q  <= rd_src_i;
          end else begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (ack_i) begin
            st_q       <= ST_IDLE;
            irq_o      <= 1'b0;
            core_vec_o <= '0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3: idle with global enable low never raises the interrupt
  p_gated_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !gie_i) |=> !irq_o);

  // R5: shared vector number accompanies the interrupt
  p_vec_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (core_vec_o == VEC_W'(CORE_VEC)));

  // R5: a result is only presented while the interrupt is up
  p_done_irq_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> irq_o);

  // R6: a matched result lies in the external dispatch range
  p_range_r6: assert property (@(posedge clk) disable iff (rst)
    (done_o && !spur_o) |-> (disp_o >= DISP_W'(DISP_BASE)));

  // R7: done is a single-cycle pulse
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9: the snapshot holds once a scan is under way
  p_snap_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |=> $stable(snap_q));

  // R10: acknowledge of a held result drops the interrupt
  p_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && ack_i) |=> !irq_o);
endmodule

// File: rtl/ext_irq_dispatch.sv
module ext_irq_dispatch #(
  parameter int NSRC      = 32,
  parameter int DEPTH     = 32,
  parameter int DISP_BASE = 32,
  parameter int VEC_W     = 5,
  parameter int CORE_VEC  = 4,
  localparam int SRC_W    = $clog2(NSRC),
  localparam int AW       = $clog2(DEPTH),
  localparam int PTR_W    = $clog2(DEPTH + 1),
  localparam int DISP_W   = $clog2(DISP_BASE + NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_in,
  input  logic [NSRC-1:0]   src_en,
  input  logic              gie,
  input  logic              ack,
  input  logic              tbl_we,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [SRC_W-1:0]  tbl_src,
  input  logic              tbl_vld,
  input  logic              len_we,
  input  logic [PTR_W-1:0]  len_val,
  output logic              irq_out,
  output logic [VEC_W-1:0]  core_vec,
  output logic              done,
  output logic [DISP_W-1:0] disp_num,
  output logic              spurious
);
  logic [NSRC-1:0]  req;
  logic [NSRC-1:0]  clr;
  logic             lock;
  logic [AW-1:0]    rd_ptr;
  logic [SRC_W-1:0] rd_src;
  logic             rd_vld;
  logic [PTR_W-1:0] scan_len;

  eid_req_bank #(.NSRC(NSRC)) u_req (
    .clk   (clk),
    .rst   (rst),
    .set_i (irq_in),
    .clr_i (clr),
    .req_o (req)
  );

  eid_order_tbl #(
    .DEPTH (DEPTH),
    .SRC_W (SRC_W),
    .AW    (AW),
    .PTR_W (PTR_W)
  ) u_tbl (
    .clk       (clk),
    .rst       (rst),
    .lock_i    (lock),
    .wr_en_i   (tbl_we),
    .wr_addr_i (tbl_addr),
    .wr_src_i  (tbl_src),
    .wr_vld_i  (tbl_vld),
    .len_we_i  (len_we),
    .len_val_i (len_val),
    .rd_ptr_i  (rd_ptr),
    .rd_src_o  (rd_src),
    .rd_vld_o  (rd_vld),
    .len_o     (scan_len)
  );

  eid_scan_fsm #(
    .NSRC      (NSRC),
    .SRC_W     (SRC_W),
    .AW        (AW),
    .PTR_W     (PTR_W),
    .DISP_W    (DISP_W),
    .DISP_BASE (DISP_BASE),
    .VEC_W     (VEC_W),
    .CORE_VEC  (CORE_VEC)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req),
    .en_i       (src_en),
    .gie_i      (gie),
    .ack_i      (ack),
    .rd_src_i   (rd_src),
    .rd_vld_i   (rd_vld),
    .len_i      (scan_len),
    .rd_ptr_o   (rd_ptr),
    .lock_o     (lock),
    .clr_o      (clr),
    .irq_o      (irq_out),
    .core_vec_o (core_vec),
    .done_o     (done),
    .disp_o     (disp_num),
    .spur_o     (spurious)
  );
endmodule

// File: tb/tb_ext_irq_dispatch.sv
module tb_ext_irq_dispatch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] irq_in, src_en;
  logic        gie, ack, tbl_we, tbl_vld, len_we;
  logic [4:0]  tbl_addr, tbl_src;
  logic [5:0]  len_val;
  logic        irq_out, done, spurious;
  logic [4:0]  core_vec;
  logic [5:0]  disp_num;

  ext_irq_dispatch dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .src_en(src_en), .gie(gie),
    .ack(ack), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_src(tbl_src),
    .tbl_vld(tbl_vld), .len_we(len_we), .len_val(len_val),
    .irq_out(irq_out), .core_vec(core_vec), .done(done),
    .disp_num(disp_num), .spurious(spurious)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench model of the programmed state
  bit          m_vld [32];
  logic [4:0]  m_src [32];
  int          m_len = 0;
  logic [31:0] m_req = '0;
  logic [31:0] m_en  = '0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wr_ent(int a, int s, bit v, bit upd);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a[4:0]; tbl_src = s[4:0]; tbl_vld = v;
    @(negedge clk);
    tbl_we = 1'b0;
    if (upd) begin m_vld[a] = v; m_src[a] = s[4:0]; end
  endtask

  task automatic wr_len(int l, bit upd);
    @(negedge clk);
    len_we = 1'b1; len_val = l[5:0];
    @(negedge clk);
    len_we = 1'b0;
    if (upd) m_len = (l > 32) ? 32 : l;
  endtask

  task automatic pulse(logic [31:0] b);
    @(negedge clk);
    irq_in = b;
    @(negedge clk);
    irq_in = '0;
    m_req |= b;
  endtask

  task automatic expect_quiet(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(irq_out == 1'b0, tag, "irq_out quiet", irq_out, 0);
    end
  endtask

  // expected result from the bench's own table model
  function automatic int exp_pos(logic [31:0] snap);
    for (int p = 0; p < m_len; p++)
      if (m_vld[p] && snap[m_src[p]]) return p;
    return -1;
  endfunction

  task automatic run_dispatch(logic [31:0] late, bit rej, string tag);
    logic [31:0] snap;
    int pos, n, lat, exp_lat, exp_disp;
    snap = m_req & m_en;
    pos = exp_pos(snap);
    exp_lat  = (pos >= 0) ? pos + 1 : m_len + 1;
    exp_disp = (pos >= 0) ? 32 + int'(m_src[pos]) : 0;
    n = 0;
    while (!irq_out && n < 20) begin @(negedge clk); n++; end
    check(irq_out == 1'b1, tag, "R5 irq_out raised", irq_out, 1);
    check(core_vec == 5'd4, tag, "R5 core_vec", core_vec, 4);
    irq_in = late;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      if (lat == 0) irq_in = '0;
      lat++;
    end
    m_req |= late;
    check(done == 1'b1, tag, "R7 done seen", done, 1);
    check(lat == exp_lat, tag, "R7 done latency", lat, exp_lat);
    check(spurious == (pos < 0), tag, "R8 spurious", spurious, pos < 0);
    check(disp_num == exp_disp[5:0], tag, "R6 disp_num", disp_num, exp_disp);
    if (rej) begin
      wr_ent(0, 5, 1'b1, 1'b0);
      wr_len(0, 1'b0);
      check(irq_out == 1'b1, tag, "R10 held until ack", irq_out, 1);
    end
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check(irq_out == 1'b0, tag, "R10 irq_out after ack", irq_out, 0);
    check(core_vec == 5'd0, tag, "R5 core_vec after ack", core_vec, 0);
    if (pos >= 0) m_req &= ~(32'd1 << m_src[pos]);
    else          m_req &= ~snap;
  endtask

  task automatic drain(string tag);
    while ((m_req & m_en) != '0) run_dispatch('0, 1'b0, tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] bits;
    rst = 1'b1; irq_in = '0; src_en = '0; gie = 1'b0; ack = 1'b0;
    tbl_we = 1'b0; tbl_addr = '0; tbl_src = '0; tbl_vld = 1'b0;
    len_we = 1'b0; len_val = '0;
    for (int i = 0; i < 32; i++) begin m_vld[i] = 1'b0; m_src[i] = '0; end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(irq_out == 1'b0, "R1", "irq_out", irq_out, 0);
    check(done == 1'b0, "R1", "done", done, 0);
    check(spurious == 1'b0, "R1", "spurious", spurious, 0);
    check(disp_num == 6'd0, "R1", "disp_num", disp_num, 0);
    check(core_vec == 5'd0, "R1", "core_vec", core_vec, 0);

    // R1: length 0 after reset gives a one-cycle spurious scan
    m_en = '1; src_en = '1; gie = 1'b1;
    pulse(32'h1);
    run_dispatch('0, 1'b0, "R1 zero length");

    // program table: 9, 3, (20 invalid), 20
    for (int a = 0; a < 32; a++) wr_ent(a, 0, 1'b0, 1'b1);
    wr_ent(0, 9, 1'b1, 1'b1);
    wr_ent(1, 3, 1'b1, 1'b1);
    wr_ent(2, 20, 1'b0, 1'b1);
    wr_ent(3, 20, 1'b1, 1'b1);
    wr_len(4, 1'b1);

    // R7 order beats bit position, R2 leftover is rescanned
    pulse((32'd1 << 3) | (32'd1 << 9));
    run_dispatch('0, 1'b0, "R7 slot order");
    check(m_req == (32'd1 << 3), "R2", "model leftover", m_req, 32'd1 << 3);
    run_dispatch('0, 1'b0, "R2 leftover rescan");

    // R8 invalid slot skipped
    pulse(32'd1 << 20);
    run_dispatch('0, 1'b0, "R8 invalid slot");
    // R8 unconfigured source -> spurious, cleared by ack
    pulse(32'd1 << 17);
    run_dispatch('0, 1'b0, "R8 spurious");
    expect_quiet(3, "R8 spurious cleared");
    // R8 slot beyond length
    wr_len(3, 1'b1);
    pulse(32'd1 << 20);
    run_dispatch('0, 1'b0, "R8 beyond length");
    wr_len(4, 1'b1);

    // R4 masked request
    m_en = ~(32'd1 << 3); src_en = m_en;
    pulse(32'd1 << 3);
    expect_quiet(4, "R4 masked");
    @(negedge clk);
    m_en = '1; src_en = '1;
    run_dispatch('0, 1'b0, "R4 unmasked later");

    // R3 global disable, R10 ack while idle
    gie = 1'b0;
    pulse(32'd1 << 9);
    expect_quiet(4, "R3 gie low");
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    expect_quiet(2, "R10 idle ack");
    gie = 1'b1;
    run_dispatch('0, 1'b0, "R3 served after gie");

    // R9 late request not in snapshot
    pulse(32'd1 << 3);
    run_dispatch(32'd1 << 9, 1'b0, "R9 snapshot");
    run_dispatch('0, 1'b0, "R9 late served next");

    // R11 writes dropped while busy
    pulse(32'd1 << 9);
    run_dispatch('0, 1'b1, "R11 busy write");
    pulse(32'd1 << 5);
    run_dispatch('0, 1'b0, "R11 table unchanged");

    // random phase
    for (int pass = 0; pass < 3; pass++) begin
      gie = 1'b0;
      for (int a = 0; a < 32; a++)
        wr_ent(a, int'($urandom % 32), ($urandom % 4) != 0, 1'b1);
      wr_len(int'($urandom % 34), 1'b1);
      @(negedge clk);
      m_en = $urandom | $urandom; src_en = m_en;
      gie = 1'b1;
      drain("R7 random drain");
      for (int it = 0; it < 40; it++) begin
        bits = $urandom & $urandom & $urandom;
        if (bits == '0) bits = 32'd1 << ($urandom % 32);
        pulse(bits);
        if ((m_req & m_en) == '0) expect_quiet(3, "R4 random masked");
        else drain("R7 random");
      end
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule